// File: doc/BRIEF.md
# Timestamped Cluster Sample Packer

This block turns a stream of probe samples into the word stream that a logic analyzer writes to its sample memory. Samples arrive on a strobe. Complete events are grouped into clusters. A cluster is one 16-bit timestamp word followed by seven 16-bit event words. Memory is organised in chunks of 512 words, which is 64 clusters.

Clusters are only written while the inputs are changing, so long quiet stretches cost nothing in memory. The timestamp of each cluster is the number of the tick that holds its first event. A reader treats any ticks between the end of one cluster and the timestamp of the next as repeats of the last stored sample.

A mode captured during reset sets how many sub-samples make up one event: one, two or four. With more sub-samples per event, fewer channels fit. Each event then interleaves several sub-samples of fewer channels, which suits the faster capture rates.

The block also provides the following:
- A stop request closes the capture and pads any open cluster.
- The memory write position is given as a chunk index and a word slot within the chunk.
- A done flag reports that the stream has drained.

Top module: `tcp_packer`

## Requirements
- R1: After reset, `out_valid_o` and `done_o` are 0, and the write position `{wr_chunk_o, wr_slot_o}` is 0.
- R2: The mode is taken from `mode_i` while `rst` is high. The encodings are:
  - 2'b00 and 2'b11: 16 channels, 1 sub-sample per event.
  - 2'b01: 8 channels, 2 sub-samples per event.
  - 2'b10: 4 channels, 4 sub-samples per event.

  Each `smp_vld_i` strobe supplies one sub-sample from `probe_i[C-1:0]`, where C is the channel count. Within an event word, sub-sample k of channel l is placed at bit l*S+k, where S is the number of sub-samples per event.
- R3: The last stored sample is the final sub-sample of the most recently stored event; it is 0 after reset. When no cluster is open, an event is dropped if every one of its sub-samples equals the last stored sample on the active channels. Probe bits at C and above never affect the output.
- R4: The tick counter starts at 0 after reset and counts completed events modulo 2^16. Any event that is not dropped opens a cluster. The cluster's timestamp word is the tick of that opening event. The next six completed events are stored unconditionally.
- R5: While no cluster is open, an event is forced to open a cluster when the current tick minus the previous cluster's timestamp (0 after reset) equals 16'hFFFF. This applies even if the event repeats the last stored sample.
- R6: The words of a cluster are presented in order, starting with the timestamp. The first word is valid in the cycle after the edge that completes the seventh event. One word advances per cycle in which `out_valid_o` and `out_ready_i` are both high. `out_valid_o` and `out_data_o` hold while `out_ready_i` is low.
- R7: The write position counts accepted words. `wr_slot_o` is that count modulo 512, and `wr_chunk_o` is the count divided by 512.
- R8: A `stop_i` pulse has the following effects:
  - Any sub-samples of an unfinished event are discarded.
  - An open cluster has its empty slots filled with copies of its last stored event, and is presented from the next cycle.
  - A strobe in the same cycle as the stop, and every strobe after it, is ignored.
  - Once stopped and drained, `done_o` is high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the mode |
| mode_i | input | 2 | Channel/sub-sample mode, sampled during reset |
| smp_vld_i | input | 1 | Sub-sample strobe |
| probe_i | input | 16 | Probe levels |
| stop_i | input | 1 | Stop request pulse |
| out_data_o | output | 16 | Cluster word |
| out_valid_o | output | 1 | Cluster word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| wr_chunk_o | output | POS_W-9 | Chunk index of the next word |
| wr_slot_o | output | 9 | Word slot of the next word inside its chunk |
| done_o | output | 1 | Stopped and fully drained |

## Verification
The three results fall due at fixed points after their stimulus:
- A cluster's first word is due one edge after the strobe that completes its seventh event, or one edge after a stop that flushes it.
- The write position is due one edge after each accepted word.
- `done_o` is due on the edge that hands over the last word.

The bench drives and samples on the falling edge, halfway between the edges. It keeps a queue of the words the model expects. At every falling edge it checks that `out_valid_o` equals "queue not empty", that the position equals the count of words already accepted, and that `done_o` matches. For each word accepted on the following rising edge, it compares `out_data_o` with the head of the queue.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

    localparam int NCH       = 16;  // probe inputs
    localparam int WORD_W    = 16;  // memory word width
    localparam int TS_W      = 16;  // timestamp width
    localparam int EV_PER_CL = 7;   // events per cluster
    localparam int CL_WORDS  = EV_PER_CL + 1;
    localparam int CHUNK_LG  = 9;   // log2 of words per chunk
    localparam int CNT_W     = $clog2(CL_WORDS);

    typedef enum logic [1:0] {
        MODE_W16 = 2'b00,
        MODE_W8  = 2'b01,
        MODE_W4  = 2'b10,
        MODE_RSV = 2'b11
    } mode_e;

    // log2 of sub-samples per event
    function automatic logic [1:0] sub_shift(mode_e m);
        case (m)
            MODE_W8: return 2'd1;
            MODE_W4: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // active channel mask for a given sub-sample shift
    function automatic logic [NCH-1:0] chan_mask(logic [1:0] sh);
        case (sh)
            2'd1:    return NCH'(16'h00FF);
            2'd2:    return NCH'(16'h000F);
            default: return {NCH{1'b1}};
        endcase
    endfunction

    typedef struct packed {
        logic              done;  // event completed this cycle
        logic              rpt;   // all sub-samples repeat the last sample
        logic [WORD_W-1:0] word;  // interleaved event word
        logic [NCH-1:0]    last;  // final sub-sample, masked
    } event_t;

    typedef struct packed {
        logic [TS_W-1:0]                     ts;
        logic [EV_PER_CL-1:0][WORD_W-1:0]    ev;
    } cluster_t;

endpackage

// File: rtl/tcp_event_interleave.sv
module tcp_event_interleave
    import tcp_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     sh,
    input  logic           vld,
    input  logic           halt,
    input  logic [NCH-1:0] probe,
    input  logic [NCH-1:0] last_smp,
    output event_t         evt
);

    logic [1:0]        sub_q;
    logic [WORD_W-1:0] ev_q;
    logic              same_q;

    logic [WORD_W-1:0] ev_n;
    logic [NCH-1:0]    mask;
    logic              same_now;
    logic              acc;
    logic              fin;

    always_comb begin
        mask = chan_mask(sh);
        ev_n = ev_q;
        for (int l = 0; l < NCH; l++) begin
            if (l < (NCH >> sh))
                ev_n[(l << sh) + int'(sub_q)] = probe[l];
        end
        same_now = ((probe ^ last_smp) & mask) == '0;
        acc      = vld && !halt;
        fin      = acc && ({1'b0, sub_q} == ((3'd1 << sh) - 3'd1));
        evt.done = fin;
        evt.rpt  = same_q && same_now;
        evt.word = ev_n;
        evt.last = probe & mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q  <= '0;
            ev_q   <= '0;
            same_q <= 1'b1;
        end else if (halt) begin
            sub_q  <= '0;
            same_q <= 1'b1;
        end else if (fin) begin
            sub_q  <= '0;
            ev_q   <= '0;
            same_q <= 1'b1;
        end else if (acc) begin
            sub_q  <= sub_q + 2'd1;
            ev_q   <= ev_n;
            same_q <= same_q && same_now;
        end
    end

endmodule

// File: rtl/tcp_cluster_asm.sv
module tcp_cluster_asm
    import tcp_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  event_t         evt,
    input  logic           stop,
    output logic           halt,
    output logic [NCH-1:0] last_smp,
    output logic           ho_vld,
    output cluster_t       ho_cl,
    output logic           stopped
);

    logic [TS_W-1:0]                  tick_q;
    logic [TS_W-1:0]                  last_ts_q;
    logic [TS_W-1:0]                  ts_q;
    logic [CNT_W-1:0]                 cnt_q;
    logic [EV_PER_CL-1:0][WORD_W-1:0] evs_q;
    logic [WORD_W-1:0]                last_ev_q;
    logic [NCH-1:0]                   last_q;
    logic                             stopped_q;

    logic [TS_W-1:0] gap;
    logic            wrap_due;
    logic            take;
    logic            full;
    logic            flush;

    assign halt     = stopped_q || stop;
    assign last_smp = last_q;
    assign stopped  = stopped_q;

    always_comb begin
        gap      = tick_q - last_ts_q;
        wrap_due = &gap;
        take     = evt.done && ((cnt_q != '0) || !evt.rpt || wrap_due);
        full     = take && (cnt_q == CNT_W'(EV_PER_CL - 1));
        flush    = stop && !stopped_q && (cnt_q != '0);
        ho_vld   = full || flush;
        ho_cl.ts = ts_q;
        for (int i = 0; i < EV_PER_CL; i++) begin
            if (CNT_W'(i) < cnt_q)
                ho_cl.ev[i] = evs_q[i];
            else if (full)
                ho_cl.ev[i] = evt.word;
            else
                ho_cl.ev[i] = last_ev_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q    <= '0;
            last_ts_q <= '0;
            ts_q      <= '0;
            cnt_q     <= '0;
            evs_q     <= '0;
            last_ev_q <= '0;
            last_q    <= '0;
            stopped_q <= 1'b0;
        end else begin
            if (evt.done)
                tick_q <= tick_q + 1'b1;
            if (take) begin
                if (cnt_q == '0) begin
                    ts_q      <= tick_q;
                    last_ts_q <= tick_q;
                end
                evs_q[cnt_q] <= evt.word;
                last_ev_q    <= evt.word;
                last_q       <= evt.last;
                cnt_q        <= full ? '0 : cnt_q + 1'b1;
            end
            if (stop && !stopped_q) begin
                stopped_q <= 1'b1;
                cnt_q     <= '0;
            end
        end
    end

endmodule

// File: rtl/tcp_word_out.sv
module tcp_word_out
    import tcp_pkg::*;
#(
    parameter int POS_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ho_vld,
    input  cluster_t          ho_cl,
    input  logic              stopped,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic [POS_W-1:0]  pos,
    output logic              done
);

    logic [CL_WORDS-1:0][WORD_W-1:0] buf_q;
    logic                            busy_q;
    logic [CNT_W-1:0]                idx_q;
    logic [POS_W-1:0]                pos_q;
    logic                            fire;

    assign fire      = busy_q && out_ready;
    assign out_valid = busy_q;
    assign out_data  = buf_q[idx_q];
    assign pos       = pos_q;
    assign done      = stopped && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            busy_q <= 1'b0;
            idx_q  <= '0;
            pos_q  <= '0;
        end else begin
            if (fire)
                pos_q <= pos_q + {{(POS_W-1){1'b0}}, 1'b1};
            if (ho_vld) begin
                buf_q[0] <= ho_cl.ts;
                for (int i = 0; i < EV_PER_CL; i++)
                    buf_q[i+1] <= ho_cl.ev[i];
                busy_q <= 1'b1;
                idx_q  <= '0;
            end else if (fire) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == CNT_W'(CL_WORDS - 1))
                    busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tcp_packer.sv
module tcp_packer
    import tcp_pkg::*;
#(
    parameter int POS_W = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                mode_i,
    input  logic                      smp_vld_i,
    input  logic [15:0]               probe_i,
    input  logic                      stop_i,
    output logic [15:0]               out_data_o,
    output logic                      out_valid_o,
    input  logic                      out_ready_i,
    output logic [POS_W-CHUNK_LG-1:0] wr_chunk_o,
    output logic [CHUNK_LG-1:0]       wr_slot_o,
    output logic                      done_o
);

    logic [1:0]       mode_q;
    logic [1:0]       sh;
    event_t           evt;
    logic             halt;
    logic [NCH-1:0]   last_smp;
    logic             ho_vld;
    cluster_t         ho_cl;
    logic             stopped;
    logic [POS_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= mode_i;
    end

    assign sh = sub_shift(mode_e'(mode_q));

    tcp_event_interleave u_ilv (
        .clk      (clk),
        .rst      (rst),
        .sh       (sh),
        .vld      (smp_vld_i),
        .halt     (halt),
        .probe    (probe_i),
        .last_smp (last_smp),
        .evt      (evt)
    );

    tcp_cluster_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .stop     (stop_i),
        .halt     (halt),
        .last_smp (last_smp),
        .ho_vld   (ho_vld),
        .ho_cl    (ho_cl),
        .stopped  (stopped)
    );

    tcp_word_out #(.POS_W(POS_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .ho_vld    (ho_vld),
        .ho_cl     (ho_cl),
        .stopped   (stopped),
        .out_ready (out_ready_i),
        .out_data  (out_data_o),
        .out_valid (out_valid_o),
        .pos       (pos),
        .done      (done_o)
    );

    assign wr_chunk_o = pos[POS_W-1:CHUNK_LG];
    assign wr_slot_o  = pos[CHUNK_LG-1:0];

endmodule

// File: rtl/tcp_packer_chk.sv
module tcp_packer_chk #(
    parameter int POS_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic [15:0]      out_data_o,
    input logic [POS_W-10:0] wr_chunk_o,
    input logic [8:0]       wr_slot_o,
    input logic             done_o
);

    logic [POS_W-1:0] wpos;
    assign wpos = {wr_chunk_o, wr_slot_o};

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!out_valid_o && !done_o && wpos == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    assert_advance_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && out_ready_i) |=> (wpos == POS_W'($past(wpos) + 1'b1)));

    assert_still_R7: assert property (@(posedge clk) disable iff (rst)
        !(out_valid_o && out_ready_i) |=> $stable(wpos));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !out_valid_o);

endmodule

bind tcp_packer tcp_packer_chk #(.POS_W(POS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .wr_chunk_o  (wr_chunk_o),
    .wr_slot_o   (wr_slot_o),
    .done_o      (done_o)
);

// File: tb/tcp_packer_test.sv
module tcp_packer_test;

    localparam int POS_W = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        mode_i = 2'b00;
    logic              smp_vld_i = 1'b0;
    logic [15:0]       probe_i = '0;
    logic              stop_i = 1'b0;
    logic [15:0]       out_data_o;
    logic              out_valid_o;
    logic              out_ready_i = 1'b0;
    logic [POS_W-10:0] wr_chunk_o;
    logic [8:0]        wr_slot_o;
    logic              done_o;

    always #4 clk = ~clk;  // 125 MHz

    tcp_packer #(.POS_W(POS_W)) uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .smp_vld_i(smp_vld_i),
        .probe_i(probe_i), .stop_i(stop_i), .out_data_o(out_data_o),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .wr_chunk_o(wr_chunk_o), .wr_slot_o(wr_slot_o), .done_o(done_o)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    string tag = "R4";

    // behavioural model state
    int          m_sh, m_sub, m_tick, m_lastts, m_cnt, acc;
    bit          m_same, m_stopped;
    logic [15:0] m_ev, m_last, m_lastev;
    logic [15:0] m_cl[$];
    logic [15:0] q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[15:0] ^ lfsr[31:16];
    endfunction

    task automatic model(input bit v, input logic [15:0] p, input bit st);
        int s, c, gap;
        logic [15:0] mask;
        s = 1 << m_sh;
        c = 16 >> m_sh;
        mask = (c == 16) ? 16'hFFFF : 16'((1 << c) - 1);
        if (st && !m_stopped) begin
            if (m_cnt > 0) begin
                while (m_cl.size() < 8) m_cl.push_back(m_lastev);
                foreach (m_cl[i]) q.push_back(m_cl[i]);
            end
            m_cl.delete();
            m_cnt = 0;
            m_stopped = 1;
        end else if (v && !m_stopped) begin
            for (int l = 0; l < c; l++) m_ev[l*s + m_sub] = p[l];
            if ((p & mask) != (m_last & mask)) m_same = 0;
            m_sub++;
            if (m_sub == s) begin
                gap = (m_tick - m_lastts) & 32'hFFFF;
                if (!(m_cnt == 0 && m_same && gap != 65535)) begin
                    if (m_cnt == 0) begin
                        m_cl.delete();
                        m_cl.push_back(16'(m_tick));
                        m_lastts = m_tick;
                    end
                    m_cl.push_back(m_ev);
                    m_lastev = m_ev;
                    m_last   = p & mask;
                    m_cnt++;
                    if (m_cnt == 7) begin
                        foreach (m_cl[i]) q.push_back(m_cl[i]);
                        m_cl.delete();
                        m_cnt = 0;
                    end
                end
                m_tick = (m_tick + 1) & 32'hFFFF;
                m_sub  = 0;
                m_same = 1;
            end
        end
    endtask

    task automatic step(input bit v, input logic [15:0] p, input bit st);
        @(negedge clk);
        cyc++;
        chk(out_valid_o === (q.size() > 0), "R6", "valid", int'(out_valid_o), int'(q.size() > 0));
        chk({wr_chunk_o, wr_slot_o} === POS_W'(acc), "R7", "position",
            int'({wr_chunk_o, wr_slot_o}), acc);
        chk(done_o === (m_stopped && q.size() == 0), "R8", "done",
            int'(done_o), int'(m_stopped && q.size() == 0));
        out_ready_i = (cyc % 4) != 3;
        if (out_valid_o && out_ready_i && q.size() > 0) begin
            chk(out_data_o === q[0], tag, "word", int'(out_data_o), int'(q[0]));
            void'(q.pop_front());
            acc++;
        end
        smp_vld_i = v;
        probe_i   = p;
        stop_i    = st;
        model(v, p, st);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0);
    endtask

    task automatic reset_dut(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; mode_i = m; smp_vld_i = 0; stop_i = 0; probe_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_sh = (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : 0;
        m_sub = 0; m_tick = 0; m_lastts = 0; m_cnt = 0; acc = 0;
        m_same = 1; m_stopped = 0; m_ev = '0; m_last = '0; m_lastev = '0;
        m_cl.delete(); q.delete();
        // R1: reset state
        chk(out_valid_o === 1'b0, "R1", "valid after reset", int'(out_valid_o), 0);
        chk(done_o === 1'b0, "R1", "done after reset", int'(done_o), 0);
        chk({wr_chunk_o, wr_slot_o} === '0, "R1", "position after reset",
            int'({wr_chunk_o, wr_slot_o}), 0);
    endtask

    // R2/R3/R4/R8 per mode: changing runs, held runs with noisy unused bits, stop
    task automatic scenario(input logic [1:0] m, input int n, input string t);
        logic [15:0] hold, p;
        tag = t;
        reset_dut(m);
        hold = rnd();
        for (int i = 0; i < n; i++) begin
            if ((i % 40) < 15) begin
                p = rnd();
                hold = p;
            end else begin
                // R3: bits above the active channels are noise
                p = (m == 2'b01) ? {rnd()[15:8], hold[7:0]} :
                    (m == 2'b10) ? {rnd()[15:4], hold[3:0]} : hold;
            end
            step(1, p, 0);
            step(0, p, 0);
        end
        idle(14);
        for (int i = 0; i < 3; i++) begin
            step(1, rnd(), 0);
            step(0, '0, 0);
        end
        idle(14);
        step(1, rnd(), 1);  // R8: strobe with stop is ignored, cluster flushed
        idle(14);
        chk(done_o === 1'b1, "R8", "done after drain", int'(done_o), 1);
        for (int i = 0; i < 5; i++) step(1, rnd(), 0);  // R8: ignored after stop
        chk(q.size() == 0 && !out_valid_o, "R8", "no output after stop",
            int'(out_valid_o), 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        scenario(2'b00, 300, "R4");
        scenario(2'b01, 400, "R2");
        scenario(2'b10, 600, "R2");
        scenario(2'b11, 200, "R2");
        // R5: constant input forces a cluster at the 16'hFFFF gap
        tag = "R5";
        reset_dut(2'b00);
        for (int i = 0; i < 65560; i++) step(1, 16'h0000, 0);
        idle(14);
        chk(acc == 8, "R5", "forced cluster words", acc, 8);
        step(0, '0, 1);
        idle(4);
        chk({wr_chunk_o, wr_slot_o} === POS_W'(8), "R7", "final position",
            int'({wr_chunk_o, wr_slot_o}), 8);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R6 actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule